// File: doc/BRIEF.md
# PTP Event Frame Classifier

This block watches an Ethernet frame as it streams past, one byte per accepted cycle, and decides whether the frame carries a PTP message. A PTP event message needs a hardware timestamp, so it raises a timestamp strobe. A PTP general message raises a separate strobe, and any other traffic raises neither. The classifier sits beside a receive or transmit datapath at the chosen capture point. It never stalls or modifies the stream.

A mode input chooses the transport to recognise. In the first mode the PTP header follows the EtherType directly. In the second it follows a UDP header inside IPv4 or IPv6. Up to two stacked VLAN tags are skipped in either mode. With each strobe the block presents the message type, domain number and sequence identifier taken from the PTP header, which are the keys a timestamp queue needs for association. An optional domain filter rejects frames from other domains. Two saturating counters record frames that matched and frames that did not.

Top module: `ptp_frame_classifier`

## Requirements
- R1: After reset both strobes are low, the extracted fields are zero and both counters are zero.
- R2: In Ethernet mode (cfgUdpMode=0), a frame with EtherType 0x88F7 is PTP. Its class comes from the low nibble of PTP header byte 0: values 0 to 3 raise tsStrobe and any other value raises genStrobe.
- R3: With a strobe, msgType shows the low nibble of PTP header byte 0 and domainNum shows header byte 4. seqId shows header bytes 30 and 31, with byte 30 as the high byte.
- R4: In UDP mode (cfgUdpMode=1), an IPv4 frame (EtherType 0x0800, version 4, IHL of at least 5) matches only when the protocol byte at IP offset 9 equals 17. The UDP header starts at IHL×4 bytes. Destination port 319 raises tsStrobe, port 320 raises genStrobe, and any other port is a miss. The PTP header starts 8 bytes after the UDP header.
- R5: In UDP mode, an IPv6 frame (EtherType 0x86DD) matches only when the next-header byte at IP offset 6 equals 17. The UDP header then follows a fixed 40-byte IP header, and the ports are handled as in R4.
- R6: A tag with TPID 0x8100 or 0x88A8 at the EtherType position moves that position 4 bytes later, for at most two tags. A third tag is taken as the EtherType and the frame misses.
- R7: Only the transport chosen by cfgUdpMode can match. A frame of the other transport, or one with an unrelated EtherType, misses.
- R8: When cfgDomainEn=1, a PTP frame whose domain byte differs from cfgDomain raises no strobe and counts as a miss.
- R9: hitCount increases by one for each frame that raises a strobe and holds at its all-ones maximum.
- R10: missCount increases by one, at the end-of-frame byte, for each frame that raised no strobe, including a frame that ends before PTP header byte 31. It holds at all-ones.
- R11: A strobe lasts one cycle and is high in the cycle after the edge that accepts PTP header byte 31. A frame raises at most one strobe, and tsStrobe and genStrobe are never high together. A frame whose end marker falls on header byte 31 still matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A frame byte is present this cycle |
| inSof | input | 1 | Current byte is the first byte of a frame |
| inEof | input | 1 | Current byte is the last byte of a frame |
| inByte | input | 8 | Frame byte, destination address first |
| cfgUdpMode | input | 1 | 0: PTP over Ethernet, 1: PTP over UDP |
| cfgDomainEn | input | 1 | Enable the domain filter |
| cfgDomain | input | 8 | Domain accepted when the filter is on |
| tsStrobe | output | 1 | Event message matched, timestamp it |
| genStrobe | output | 1 | General message matched |
| msgType | output | 4 | Message type of the last matched frame |
| domainNum | output | 8 | Domain of the last matched frame |
| seqId | output | 16 | Sequence identifier of the last matched frame |
| hitCount | output | CNT_W | Saturating count of matched frames |
| missCount | output | CNT_W | Saturating count of unmatched frames |

## Verification
A strobe, the field outputs and the hit counter all change at the clock edge that accepts PTP header byte 31. They become visible one cycle later. The miss counter changes at the edge that accepts the end-of-frame byte. The bench drives one byte per falling edge. Before it drives byte i, it looks at the strobes and credits any pulse it sees to byte i−1. It then compares that byte index with the header offset plus 31 and expects exactly one pulse per matching frame. It reads the counters two falling edges after the last byte, when both are due.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [2:0] {
    ST_ETH,
    ST_IP4,
    ST_IP6,
    ST_UDP,
    ST_PTP,
    ST_DONE
  } parseState_e;

  // strobes from the parser control to the field/counter datapath
  typedef struct packed {
    logic frameStart;
    logic frameEnd;
    logic capType;
    logic capDom;
    logic capSeqHi;
    logic decide;
    logic isEvent;
  } ctlStrobe_t;

  localparam logic [15:0] TPID_CUST  = 16'h8100;
  localparam logic [15:0] TPID_SERV  = 16'h88A8;
  localparam logic [15:0] ETYPE_PTP  = 16'h88F7;
  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [15:0] ETYPE_IPV6 = 16'h86DD;
  localparam logic [15:0] PORT_EVENT = 16'd319;
  localparam logic [15:0] PORT_GEN   = 16'd320;
  localparam logic [7:0]  PROTO_UDP  = 8'd17;

endpackage

// File: rtl/pfc_ctrl.sv
module pfc_ctrl
  import pfc_pkg::*;
#(
  parameter int POS_W    = 11,
  parameter int MAX_TAGS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       inSof,
  input  logic       inEof,
  input  logic [7:0] inByte,
  input  logic       cfgUdpMode,
  output ctlStrobe_t ctl
);

  localparam int TAG_W = $clog2(MAX_TAGS + 1);
  localparam logic [POS_W-1:0] TYPE_OFF = POS_W'(12);
  localparam logic [POS_W-1:0] POS_MAX  = '1;

  logic               inFrame;
  logic [POS_W-1:0]   pos, curPos, rel;
  parseState_e        state, effState, nState;
  logic [POS_W-1:0]   baseOff, effBase, nBase;
  logic [TAG_W-1:0]   tagCnt, effTags, nTags;
  logic [7:0]         hiByte, nHi;
  logic [3:0]         ihl, nIhl;
  logic               evtClass, nEvt;
  logic               accept;
  logic [15:0]        word;

  assign accept   = inValid && (inSof || inFrame);
  assign curPos   = inSof ? '0 : pos;
  assign effState = inSof ? ST_ETH : state;
  assign effBase  = inSof ? TYPE_OFF : baseOff;
  assign effTags  = inSof ? '0 : tagCnt;
  assign rel      = curPos - effBase;
  assign word     = {hiByte, inByte};

  always_comb begin
    nState = effState;
    nBase  = effBase;
    nTags  = effTags;
    nHi    = hiByte;
    nIhl   = ihl;
    nEvt   = evtClass;
    ctl            = '0;
    ctl.frameStart = accept && inSof;
    ctl.frameEnd   = accept && inEof;
    ctl.isEvent    = evtClass;
    if (accept) begin
      unique case (effState)
        ST_ETH: begin
          if (rel == POS_W'(0)) nHi = inByte;
          if (rel == POS_W'(1)) begin
            if ((word == TPID_CUST || word == TPID_SERV) && effTags < TAG_W'(MAX_TAGS)) begin
              nTags = effTags + TAG_W'(1);
              nBase = effBase + POS_W'(4);
            end else if (!cfgUdpMode && word == ETYPE_PTP) begin
              nState = ST_PTP;
              nBase  = effBase + POS_W'(2);
            end else if (cfgUdpMode && word == ETYPE_IPV4) begin
              nState = ST_IP4;
              nBase  = effBase + POS_W'(2);
            end else if (cfgUdpMode && word == ETYPE_IPV6) begin
              nState = ST_IP6;
              nBase  = effBase + POS_W'(2);
            end else begin
              nState = ST_DONE;
            end
          end
        end
        ST_IP4: begin
          if (rel == POS_W'(0)) begin
            if (inByte[7:4] != 4'd4 || inByte[3:0] < 4'd5) nState = ST_DONE;
            else nIhl = inByte[3:0];
          end
          if (rel == POS_W'(9)) begin
            if (inByte == PROTO_UDP) begin
              nState = ST_UDP;
              nBase  = effBase + POS_W'({ihl, 2'b00});
            end else begin
              nState = ST_DONE;
            end
          end
        end
        ST_IP6: begin
          if (rel == POS_W'(6)) begin
            if (inByte == PROTO_UDP) begin
              nState = ST_UDP;
              nBase  = effBase + POS_W'(40);
            end else begin
              nState = ST_DONE;
            end
          end
        end
        ST_UDP: begin
          if (rel == POS_W'(2)) nHi = inByte;
          if (rel == POS_W'(3)) begin
            nBase = effBase + POS_W'(8);
            if (word == PORT_EVENT) begin
              nState = ST_PTP;
              nEvt   = 1'b1;
            end else if (word == PORT_GEN) begin
              nState = ST_PTP;
              nEvt   = 1'b0;
            end else begin
              nState = ST_DONE;
            end
          end
        end
        ST_PTP: begin
          if (rel == POS_W'(0)) begin
            ctl.capType = 1'b1;
            if (!cfgUdpMode) nEvt = (inByte[3:0] < 4'd4);
          end
          if (rel == POS_W'(4))  ctl.capDom   = 1'b1;
          if (rel == POS_W'(30)) ctl.capSeqHi = 1'b1;
          if (rel == POS_W'(31)) begin
            ctl.decide = 1'b1;
            nState     = ST_DONE;
          end
        end
        default: nState = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inFrame  <= 1'b0;
      pos      <= '0;
      state    <= ST_DONE;
      baseOff  <= TYPE_OFF;
      tagCnt   <= '0;
      hiByte   <= '0;
      ihl      <= '0;
      evtClass <= 1'b0;
    end else if (accept) begin
      inFrame  <= !inEof;
      pos      <= (curPos == POS_MAX) ? curPos : curPos + POS_W'(1);
      state    <= nState;
      baseOff  <= nBase;
      tagCnt   <= nTags;
      hiByte   <= nHi;
      ihl      <= nIhl;
      evtClass <= nEvt;
    end
  end

endmodule

// File: rtl/pfc_datapath.sv
module pfc_datapath
  import pfc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobe_t       ctl,
  input  logic [7:0]       inByte,
  input  logic             cfgDomainEn,
  input  logic [7:0]       cfgDomain,
  output logic             tsStrobe,
  output logic             genStrobe,
  output logic [3:0]       msgType,
  output logic [7:0]       domainNum,
  output logic [15:0]      seqId,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [3:0] typeCap;
  logic [7:0] domCap;
  logic [7:0] seqHiCap;
  logic       hitFrame;
  logic       domOk, hitNow, hitSoFar;

  assign domOk    = !cfgDomainEn || (domCap == cfgDomain);
  assign hitNow   = ctl.decide && domOk;
  assign hitSoFar = hitFrame && !ctl.frameStart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tsStrobe  <= 1'b0;
      genStrobe <= 1'b0;
      msgType   <= '0;
      domainNum <= '0;
      seqId     <= '0;
      hitCount  <= '0;
      missCount <= '0;
      typeCap   <= '0;
      domCap    <= '0;
      seqHiCap  <= '0;
      hitFrame  <= 1'b0;
    end else begin
      tsStrobe  <= hitNow && ctl.isEvent;
      genStrobe <= hitNow && !ctl.isEvent;
      if (ctl.capType)  typeCap  <= inByte[3:0];
      if (ctl.capDom)   domCap   <= inByte;
      if (ctl.capSeqHi) seqHiCap <= inByte;
      if (hitNow) begin
        msgType   <= typeCap;
        domainNum <= domCap;
        seqId     <= {seqHiCap, inByte};
        if (hitCount != CNT_MAX) hitCount <= hitCount + CNT_ONE;
      end
      if (ctl.frameStart) hitFrame <= 1'b0;
      if (hitNow)         hitFrame <= 1'b1;
      if (ctl.frameEnd && !hitSoFar && !hitNow && missCount != CNT_MAX)
        missCount <= missCount + CNT_ONE;
    end
  end

endmodule

// File: rtl/ptp_frame_classifier.sv
module ptp_frame_classifier
  import pfc_pkg::*;
#(
  parameter int POS_W    = 11,
  parameter int MAX_TAGS = 2,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEof,
  input  logic [7:0]       inByte,
  input  logic             cfgUdpMode,
  input  logic             cfgDomainEn,
  input  logic [7:0]       cfgDomain,
  output logic             tsStrobe,
  output logic             genStrobe,
  output logic [3:0]       msgType,
  output logic [7:0]       domainNum,
  output logic [15:0]      seqId,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount
);

  ctlStrobe_t ctl;

  pfc_ctrl #(.POS_W(POS_W), .MAX_TAGS(MAX_TAGS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .inValid    (inValid),
    .inSof      (inSof),
    .inEof      (inEof),
    .inByte     (inByte),
    .cfgUdpMode (cfgUdpMode),
    .ctl        (ctl)
  );

  pfc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .inByte      (inByte),
    .cfgDomainEn (cfgDomainEn),
    .cfgDomain   (cfgDomain),
    .tsStrobe    (tsStrobe),
    .genStrobe   (genStrobe),
    .msgType     (msgType),
    .domainNum   (domainNum),
    .seqId       (seqId),
    .hitCount    (hitCount),
    .missCount   (missCount)
  );

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tsStrobe,
  input logic             genStrobe,
  input logic [7:0]       domainNum,
  input logic             cfgDomainEn,
  input logic [7:0]       cfgDomain,
  input logic [CNT_W-1:0] hitCount,
  input logic [CNT_W-1:0] missCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tsStrobe && genStrobe));

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tsStrobe || genStrobe) |=> !(tsStrobe || genStrobe));

  a_r9_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tsStrobe || genStrobe) |->
      (hitCount == $past(hitCount) + CNT_ONE) || ($past(hitCount) == CNT_MAX && hitCount == CNT_MAX));

  a_r9_hit_only_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    !(tsStrobe || genStrobe) |-> $stable(hitCount));

  a_r10_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(missCount) || (missCount == $past(missCount) + CNT_ONE && !(tsStrobe || genStrobe)));

  a_r8_domain: assert property (@(posedge clk) disable iff (!rst_n)
    ((tsStrobe || genStrobe) && cfgDomainEn) |-> domainNum == cfgDomain);

endmodule

bind ptp_frame_classifier pfc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tsStrobe    (tsStrobe),
  .genStrobe   (genStrobe),
  .domainNum   (domainNum),
  .cfgDomainEn (cfgDomainEn),
  .cfgDomain   (cfgDomain),
  .hitCount    (hitCount),
  .missCount   (missCount)
);

// File: tb/sim_ptp_frame_classifier.sv
module sim_ptp_frame_classifier;

  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [7:0] inByte = '0;
  logic cfgUdpMode = 1'b0, cfgDomainEn = 1'b0;
  logic [7:0] cfgDomain = '0;
  logic tsStrobe, genStrobe;
  logic [3:0] msgType;
  logic [7:0] domainNum;
  logic [15:0] seqId;
  logic [CW-1:0] hitCount, missCount;

  always #10 clk = ~clk;

  ptp_frame_classifier #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inByte(inByte), .cfgUdpMode(cfgUdpMode), .cfgDomainEn(cfgDomainEn),
    .cfgDomain(cfgDomain), .tsStrobe(tsStrobe), .genStrobe(genStrobe),
    .msgType(msgType), .domainNum(domainNum), .seqId(seqId),
    .hitCount(hitCount), .missCount(missCount)
  );

  int checks = 0, fails = 0;
  int expHit = 0, expMiss = 0;
  logic [7:0] frm [0:159];
  int flen, po;
  int seenCnt, seenPos, seenKind;
  logic [3:0] seenMt;
  logic [7:0] seenDom;
  logic [15:0] seenSeq;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // mode: 0 Ethernet, 1 IPv4, 2 IPv6
  task automatic frame(input int tags, input int mode, input int ihl, input logic [7:0] l4,
                       input logic [15:0] port, input logic [15:0] etOvr,
                       input logic [3:0] mt, input logic [7:0] dom, input logic [15:0] seq);
    int p;
    logic [15:0] et;
    for (int i = 0; i < 160; i++) frm[i] = 8'h00;
    for (int i = 0; i < 12; i++) frm[i] = 8'(i + 1);
    p = 12;
    for (int t = 0; t < tags; t++) begin
      {frm[p], frm[p+1]} = (t % 2 == 0) ? 16'h88A8 : 16'h8100;
      {frm[p+2], frm[p+3]} = 16'h0064 + 16'(t);
      p += 4;
    end
    et = (mode == 0) ? 16'h88F7 : (mode == 1) ? 16'h0800 : 16'h86DD;
    if (etOvr != 16'h0) et = etOvr;
    {frm[p], frm[p+1]} = et;
    p += 2;
    if (mode == 1) begin
      frm[p] = 8'h40 | 8'(ihl);
      frm[p+9] = l4;
      p += ihl * 4;
    end else if (mode == 2) begin
      frm[p] = 8'h60;
      frm[p+6] = l4;
      p += 40;
    end
    if (mode != 0) begin
      frm[p] = 8'h01; frm[p+1] = 8'h3F;
      {frm[p+2], frm[p+3]} = port;
      p += 8;
    end
    po = p;
    frm[p] = {4'h1, mt};
    frm[p+1] = 8'h02;
    frm[p+4] = dom;
    frm[p+30] = seq[15:8];
    frm[p+31] = seq[7:0];
    flen = p + 38;
  endtask

  task automatic observe(input int idx);
    if (tsStrobe || genStrobe) begin
      seenCnt++;
      seenPos = idx;
      seenKind = (tsStrobe && genStrobe) ? 3 : tsStrobe ? 1 : 2;
      seenMt = msgType; seenDom = domainNum; seenSeq = seqId;
    end
  endtask

  task automatic sendFrame(input int cut);
    int n;
    n = (cut > 0 && cut < flen) ? cut : flen;
    seenCnt = 0; seenPos = -1; seenKind = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      observe(i - 1);
      inValid = 1'b1; inSof = (i == 0); inEof = (i == n - 1); inByte = frm[i];
    end
    @(negedge clk);
    observe(n - 1);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
    @(negedge clk);
    observe(n);
  endtask

  // kind: 0 none, 1 event, 2 general
  task automatic runCase(input string rq, input int kind, input logic [3:0] mt,
                         input logic [7:0] dom, input logic [15:0] seq, input int cut);
    int expPos;
    expPos = po + 31;
    sendFrame(cut);
    chk(rq, "strobe kind", 32'(seenKind), 32'(kind));
    if (kind != 0) begin
      chk("R11", "strobe byte index", 32'(seenPos), 32'(expPos));
      chk("R11", "strobes per frame", 32'(seenCnt), 32'd1);
      chk("R3", "msgType", 32'(seenMt), 32'(mt));
      chk("R3", "domainNum", 32'(seenDom), 32'(dom));
      chk("R3", "seqId", 32'(seenSeq), 32'(seq));
      expHit++;
    end else begin
      expMiss++;
    end
    chk("R9", "hitCount", 32'(hitCount), 32'((expHit > CMAX) ? CMAX : expHit));
    chk("R10", "missCount", 32'(missCount), 32'((expMiss > CMAX) ? CMAX : expMiss));
  endtask

  task automatic tReset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "strobes", {30'd0, tsStrobe, genStrobe}, 32'd0);
    chk("R1", "fields", {4'd0, msgType, domainNum, seqId}, 32'd0);
    chk("R1", "counters", {hitCount, missCount}, 32'd0);
  endtask

  task automatic tEthernet;
    cfgUdpMode = 1'b0;
    frame(0, 0, 5, 8'd0, 16'd0, 16'd0, 4'h0, 8'h2A, 16'hBEEF); runCase("R2", 1, 4'h0, 8'h2A, 16'hBEEF, 0);
    frame(0, 0, 5, 8'd0, 16'd0, 16'd0, 4'h3, 8'h2A, 16'h0001); runCase("R2", 1, 4'h3, 8'h2A, 16'h0001, 0);
    frame(0, 0, 5, 8'd0, 16'd0, 16'd0, 4'hB, 8'h07, 16'h1234); runCase("R2", 2, 4'hB, 8'h07, 16'h1234, 0);
  endtask

  task automatic tVlan;
    cfgUdpMode = 1'b0;
    frame(1, 0, 5, 8'd0, 16'd0, 16'd0, 4'h1, 8'h03, 16'h0A0B); runCase("R6", 1, 4'h1, 8'h03, 16'h0A0B, 0);
    frame(2, 0, 5, 8'd0, 16'd0, 16'd0, 4'h2, 8'h04, 16'hC0DE); runCase("R6", 1, 4'h2, 8'h04, 16'hC0DE, 0);
    frame(3, 0, 5, 8'd0, 16'd0, 16'd0, 4'h0, 8'h04, 16'h0002); runCase("R6", 0, 4'h0, 8'h04, 16'h0002, 0);
  endtask

  task automatic tModeEth;
    cfgUdpMode = 1'b0;
    frame(0, 0, 5, 8'd0, 16'd0, 16'h0806, 4'h0, 8'h00, 16'h0003); runCase("R7", 0, 4'h0, 8'h00, 16'h0003, 0);
    frame(0, 1, 5, 8'd17, 16'd319, 16'd0, 4'h0, 8'h00, 16'h0004); runCase("R7", 0, 4'h0, 8'h00, 16'h0004, 0);
  endtask

  task automatic tUdp4;
    cfgUdpMode = 1'b1;
    frame(0, 1, 5, 8'd17, 16'd319, 16'd0, 4'h0, 8'h11, 16'h5555); runCase("R4", 1, 4'h0, 8'h11, 16'h5555, 0);
    frame(0, 1, 6, 8'd17, 16'd320, 16'd0, 4'h8, 8'h12, 16'hAAAA); runCase("R4", 2, 4'h8, 8'h12, 16'hAAAA, 0);
    frame(0, 1, 5, 8'd17, 16'd1234, 16'd0, 4'h0, 8'h13, 16'h0005); runCase("R4", 0, 4'h0, 8'h13, 16'h0005, 0);
    frame(0, 1, 5, 8'd6, 16'd319, 16'd0, 4'h0, 8'h14, 16'h0006); runCase("R4", 0, 4'h0, 8'h14, 16'h0006, 0);
    frame(2, 1, 5, 8'd17, 16'd319, 16'd0, 4'h1, 8'h15, 16'h7777); runCase("R6", 1, 4'h1, 8'h15, 16'h7777, 0);
  endtask

  task automatic tUdp6;
    cfgUdpMode = 1'b1;
    frame(0, 2, 5, 8'd17, 16'd319, 16'd0, 4'h1, 8'h21, 16'h6666); runCase("R5", 1, 4'h1, 8'h21, 16'h6666, 0);
    frame(0, 2, 5, 8'd6, 16'd319, 16'd0, 4'h1, 8'h21, 16'h0007); runCase("R5", 0, 4'h1, 8'h21, 16'h0007, 0);
  endtask

  task automatic tModeUdp;
    cfgUdpMode = 1'b1;
    frame(0, 0, 5, 8'd0, 16'd0, 16'd0, 4'h0, 8'h00, 16'h0008); runCase("R7", 0, 4'h0, 8'h00, 16'h0008, 0);
  endtask

  task automatic tDomain;
    cfgUdpMode = 1'b0; cfgDomainEn = 1'b1; cfgDomain = 8'h05;
    frame(0, 0, 5, 8'd0, 16'd0, 16'd0, 4'h0, 8'h05, 16'h0909); runCase("R8", 1, 4'h0, 8'h05, 16'h0909, 0);
    frame(0, 0, 5, 8'd0, 16'd0, 16'd0, 4'h0, 8'h06, 16'h0A0A); runCase("R8", 0, 4'h0, 8'h06, 16'h0A0A, 0);
    cfgDomainEn = 1'b0;
  endtask

  task automatic tTruncate;
    cfgUdpMode = 1'b0;
    frame(0, 0, 5, 8'd0, 16'd0, 16'd0, 4'h0, 8'h01, 16'h0B0B); runCase("R10", 0, 4'h0, 8'h01, 16'h0B0B, po + 20);
    frame(0, 0, 5, 8'd0, 16'd0, 16'd0, 4'h2, 8'h01, 16'h0C0C); runCase("R11", 1, 4'h2, 8'h01, 16'h0C0C, po + 32);
  endtask

  task automatic tSaturate;
    cfgUdpMode = 1'b0;
    for (int k = 0; k < 8; k++) begin
      frame(0, 0, 5, 8'd0, 16'd0, 16'd0, 4'h0, 8'h01, 16'(k)); runCase("R9", 1, 4'h0, 8'h01, 16'(k), 0);
    end
    for (int k = 0; k < 8; k++) begin
      frame(0, 0, 5, 8'd0, 16'd0, 16'h0806, 4'h0, 8'h01, 16'(k)); runCase("R10", 0, 4'h0, 8'h01, 16'(k), 0);
    end
    chk("R9", "hitCount saturated", 32'(hitCount), 32'(CMAX));
    chk("R10", "missCount saturated", 32'(missCount), 32'(CMAX));
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    tReset();
    tEthernet();
    tVlan();
    tModeEth();
    tUdp4();
    tUdp6();
    tModeUdp();
    tDomain();
    tTruncate();
    tSaturate();
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finishRun();
  end

endmodule